// File: doc/BRIEF.md
# Shared Weighted Sample Predictor

This block scales motion-compensated samples coming out of an interpolator by a weight, rounds them, adds an offset and clips them to the 8-bit pixel range. It works on one 4x4 block (16 samples) at a time, fed as a stream of one sample per accepted beat. A block is either single-list or bi-predicted. A single-list block yields one output per input sample. A bi-predicted block is sent as 16 list-0 samples followed by 16 list-1 samples. One multiply datapath serves both lists: the list-0 products are parked in a 16-entry holding store. Each list-1 product is then summed with its stored partner at the same position, averaged and clipped.

The multiply path avoids a 9-bit multiplier. The top two bits of the 9-bit signed weight select either an 8-bit signed by sample multiply, or a plain left shift by 7 for the weight value 128. In the single-list case the rounding constant and the scaled offset are merged into one add ahead of the right shift. Every output appears exactly one clock after the sample that produces it is accepted.

Weights, offsets and the log denominator must stay stable for the whole block. The list choice is taken from the first beat of each block.

Top module: `wpred_top`

## Requirements
- R1: While reset is asserted, in_ready and out_valid are 0. From the first clock edge after reset is released, in_ready is 1.
- R2: For a single-list block with log_wd >= 1, the output is clip(((s*w0 + 2^(log_wd-1)) >> log_wd) + o0), where >> is an arithmetic shift. It is presented with out_valid = 1 in the cycle after the sample is accepted.
- R3: For a single-list block with log_wd = 0, the output is clip(s*w0 + o0).
- R4: The weight inputs are 9-bit two's complement. The value 128 (9'h080) multiplies by 128 exactly, and -128 (9'h180) multiplies by -128. With w0 = 128, log_wd = 7 and o0 = 0, the output equals the input sample.
- R5: clip() limits results to 0..255. Negative results give 0, and results above 255 give 255.
- R6: In a bi-predicted block, the first 16 accepted beats (list 0) produce no output. The next 16 beats (list 1) each produce one output. The k-th list-1 beat is combined with the k-th list-0 beat.
- R7: The bi-predicted output is clip(((s0*w0 + s1*w1 + 2^log_wd) >> (log_wd+1)) + ((o0 + o1 + 1) >> 1)).
- R8: The list choice is sampled on the first beat of each block: in_bipred = 1 means bi-predicted, 0 means single-list. in_bipred on all other beats of the block is ignored.
- R9: A cycle without an accepted beat does not advance the block position. It is followed by a cycle with out_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample beat offered |
| in_ready | output | 1 | Block can take a beat |
| in_sample | input | 8 | Interpolated sample, unsigned |
| in_bipred | input | 1 | 1 = bi-predicted block (sampled on the first beat) |
| w0 | input | 9 | List-0 weight, signed |
| o0 | input | 8 | List-0 offset, signed |
| w1 | input | 9 | List-1 weight, signed |
| o1 | input | 8 | List-1 offset, signed |
| log_wd | input | 3 | Log2 of the weight denominator, 0..7 |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 8 | Weighted, clipped sample |

## Verification
On every cycle, the assertions enforce the following timing rules:
- an accepted beat that should yield a result produces out_valid one cycle later;
- idle cycles and list-0 beats of a bi-predicted block produce nothing;
- in_ready holds high after reset;
- the weight-128 shift path returns the sample unchanged at the largest denominator.

Only the bench's scenarios can show the arithmetic. This covers the rounding at both denominators, the signed weight extremes, clipping at both ends and the pairing of list-0 and list-1 samples by position. It also covers latching the list choice on the first beat while later toggles are ignored.

// File: rtl/wpred_pkg.sv
package wpred_pkg;
  localparam int SAMPLE_W = 8;
  localparam int WGT_W    = 9;
  localparam int OFS_W    = 8;
  localparam int LOG_W    = 3;
  localparam int BLK_N    = 16;
  localparam int IDX_W    = $clog2(BLK_N);
  localparam int PROD_W   = SAMPLE_W + WGT_W;
  localparam int ACC_W    = PROD_W + 4;
  localparam int PIX_MAX  = (1 << SAMPLE_W) - 1;

  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic logic [SAMPLE_W-1:0] clip_px(input acc_t v);
    if (v < 0)
      return '0;
    else if (v > acc_t'(PIX_MAX))
      return {SAMPLE_W{1'b1}};
    else
      return v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/wpred_scale.sv
module wpred_scale
  import wpred_pkg::*;
(
  input  logic [SAMPLE_W-1:0]       sample,
  input  logic [WGT_W-1:0]          weight,
  output logic signed [PROD_W-1:0]  prod
);
  localparam int SHIFT_N = WGT_W - 2;

  logic signed [WGT_W-2:0]  w_low;
  logic signed [SAMPLE_W:0] s_ext;
  logic                     big_path;

  always_comb begin
    w_low    = weight[WGT_W-2:0];
    s_ext    = {1'b0, sample};
    big_path = (weight[WGT_W-1:WGT_W-2] == 2'b01);
    if (big_path)
      prod = {{(PROD_W-SAMPLE_W-SHIFT_N){1'b0}}, sample, {SHIFT_N{1'b0}}};
    else
      prod = PROD_W'(w_low * s_ext);
  end
endmodule

// File: rtl/wpred_hold.sv
module wpred_hold
  import wpred_pkg::*;
(
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         addr,
  input  logic signed [PROD_W-1:0] wr_data,
  output logic signed [PROD_W-1:0] rd_data
);
  logic signed [PROD_W-1:0] mem [BLK_N];

  for (genvar g = 0; g < BLK_N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (addr == IDX_W'(g)))
        mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/wpred_top.sv
module wpred_top
  import wpred_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAMPLE_W-1:0]  in_sample,
  input  logic                 in_bipred,
  input  logic [WGT_W-1:0]     w0,
  input  logic [OFS_W-1:0]     o0,
  input  logic [WGT_W-1:0]     w1,
  input  logic [OFS_W-1:0]     o1,
  input  logic [LOG_W-1:0]     log_wd,
  output logic                 out_valid,
  output logic [SAMPLE_W-1:0]  out_sample
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_N - 1);

  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                pass_q, pass_d;
  logic                bi_q, bi_d;
  logic                rdy_q;
  logic                ov_q, ov_d;
  logic [SAMPLE_W-1:0] os_q, os_d;

  logic accept, first, bi_eff, wr_en;
  logic [WGT_W-1:0] w_sel;
  logic signed [PROD_W-1:0] prod, hold_rd;
  acc_t prod_x, hold_x, ofs0_x, ofs1_x, one_x, rnd_s, acc_s, res_s, sum_b, res_b;

  assign in_ready = rdy_q;
  assign accept   = in_valid & rdy_q;
  assign first    = ~pass_q & (idx_q == '0);
  assign bi_eff   = first ? in_bipred : bi_q;
  assign w_sel    = pass_q ? w1 : w0;

  wpred_scale u_scale (
    .sample (in_sample),
    .weight (w_sel),
    .prod   (prod)
  );

  wpred_hold u_hold (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr    (idx_q),
    .wr_data (prod),
    .rd_data (hold_rd)
  );

  // arithmetic: offset and rounding merged ahead of the shift for one list
  always_comb begin
    prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    hold_x = {{(ACC_W-PROD_W){hold_rd[PROD_W-1]}}, hold_rd};
    ofs0_x = {{(ACC_W-OFS_W){o0[OFS_W-1]}}, o0};
    ofs1_x = {{(ACC_W-OFS_W){o1[OFS_W-1]}}, o1};
    one_x  = {{(ACC_W-1){1'b0}}, 1'b1};
    rnd_s  = (log_wd == '0) ? '0 : (one_x <<< (log_wd - LOG_W'(1)));
    acc_s  = prod_x + (ofs0_x <<< log_wd) + rnd_s;
    res_s  = acc_s >>> log_wd;
    sum_b  = hold_x + prod_x + (one_x <<< log_wd);
    res_b  = (sum_b >>> ({1'b0, log_wd} + (LOG_W+1)'(1)))
           + ((ofs0_x + ofs1_x + one_x) >>> 1);
  end

  always_comb begin
    idx_d  = idx_q;
    pass_d = pass_q;
    bi_d   = bi_q;
    ov_d   = 1'b0;
    os_d   = os_q;
    wr_en  = 1'b0;
    if (accept) begin
      if (first)
        bi_d = in_bipred;
      idx_d = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
      if (!pass_q && bi_eff) begin
        wr_en = 1'b1;
        if (idx_q == LAST)
          pass_d = 1'b1;
      end else if (!pass_q) begin
        ov_d = 1'b1;
        os_d = clip_px(res_s);
      end else begin
        ov_d = 1'b1;
        os_d = clip_px(res_b);
        if (idx_q == LAST)
          pass_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pass_q <= 1'b0;
      bi_q   <= 1'b0;
      rdy_q  <= 1'b0;
      ov_q   <= 1'b0;
      os_q   <= '0;
    end else begin
      idx_q  <= idx_d;
      pass_q <= pass_d;
      bi_q   <= bi_d;
      rdy_q  <= 1'b1;
      ov_q   <= ov_d;
      if (ov_d)
        os_q <= os_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_sample = os_q;

  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(!pass_q && bi_eff)) |=> out_valid);

  p_first_pass_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pass_q && bi_eff) |=> !out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);

  p_unit_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pass_q && !bi_eff && w0 == 9'h080 && log_wd == 3'd7 && o0 == '0)
      |=> (out_sample == $past(in_sample)));
endmodule

// File: tb/tb_wpred_top.sv
module tb_wpred_top;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_bipred;
  logic in_ready, out_valid;
  logic [7:0] in_sample, o0, o1, out_sample;
  logic [8:0] w0, w1;
  logic [2:0] log_wd;

  int n_chk = 0;
  int n_bad = 0;
  int ww0, ww1, oo0, oo1, ll;

  always #4 clk = ~clk;

  wpred_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_bipred(in_bipred), .w0(w0), .o0(o0),
    .w1(w1), .o1(o1), .log_wd(log_wd), .out_valid(out_valid),
    .out_sample(out_sample)
  );

  function automatic int clipv(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int single_ref(int s);
    int p = s * ww0;
    if (ll == 0) return clipv(p + oo0);
    return clipv(((p + (1 << (ll - 1))) >>> ll) + oo0);
  endfunction

  function automatic int bi_ref(int s0, int s1);
    int p = s0 * ww0 + s1 * ww1 + (1 << ll);
    return clipv((p >>> (ll + 1)) + ((oo0 + oo1 + 1) >>> 1));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setp(int a0, int b0, int a1, int b1, int l);
    ww0 = a0; oo0 = b0; ww1 = a1; oo1 = b1; ll = l;
    w0 = 9'(a0); o0 = 8'(b0); w1 = 9'(a1); o1 = 8'(b1); log_wd = 3'(l);
  endtask

  // called at a negedge; returns at the next negedge after the accept edge
  task automatic beat(int s, bit bi, bit ev, int exp, string tag);
    in_valid = 1'b1; in_sample = 8'(s); in_bipred = bi;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, int'(out_valid), int'(ev));
    if (ev) check({tag, " sample"}, int'(out_sample), exp);
  endtask

  task automatic idle(string tag);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(tag, int'(out_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; in_bipred = 1'b0;
    setp(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(in_ready), 0);
    check("R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 1);
    check("R1 valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_single;
    setp(37, -5, 0, 0, 4);
    for (int i = 0; i < 16; i++) beat(i * 17, 1'b0, 1'b1, single_ref(i * 17), "R2 single");
    setp(-21, 100, 0, 0, 1);
    for (int i = 0; i < 16; i++) beat(255 - i * 11, 1'b0, 1'b1, single_ref(255 - i * 11), "R2 single neg");
  endtask

  task automatic t_log0;
    setp(3, 10, 0, 0, 0);
    for (int i = 0; i < 16; i++) beat(i * 5, 1'b0, 1'b1, single_ref(i * 5), "R3 log0");
  endtask

  task automatic t_wext;
    setp(128, 0, 0, 0, 7);
    for (int i = 0; i < 16; i++) beat(i * 16 + 3, 1'b0, 1'b1, i * 16 + 3, "R4 w128");
    setp(-128, 127, 0, 0, 7);
    for (int i = 0; i < 16; i++) beat(i * 16, 1'b0, 1'b1, single_ref(i * 16), "R4 wm128");
  endtask

  task automatic t_clip;
    setp(127, 127, 0, 0, 0);
    for (int i = 0; i < 16; i++) beat(i + 200, 1'b0, 1'b1, 255, "R5 clip high");
    setp(-60, -3, 0, 0, 2);
    for (int i = 0; i < 16; i++) beat(i * 10 + 40, 1'b0, 1'b1, 0, "R5 clip low");
  endtask

  task automatic t_bi;
    setp(20, 4, -7, -9, 3);
    for (int i = 0; i < 16; i++) beat(i * 13, (i == 0), 1'b0, 0, "R6 list0 silent");
    for (int i = 0; i < 16; i++) beat(255 - i * 9, 1'b0, 1'b1, bi_ref(i * 13, 255 - i * 9), "R7 bi");
    setp(64, -128, 64, 127, 6);
    for (int i = 0; i < 16; i++) beat(i * 7, 1'b1, 1'b0, 0, "R6 list0 silent b");
    for (int i = 0; i < 16; i++) beat(250 - i, 1'b1, 1'b1, bi_ref(i * 7, 250 - i), "R7 bi b");
  endtask

  task automatic t_gaps;
    setp(50, 0, 90, 2, 5);
    for (int i = 0; i < 16; i++) begin
      beat(i * 15 + 1, (i == 0), 1'b0, 0, "R6 gap list0");
      if (i % 3 == 0) idle("R9 idle list0");
    end
    for (int i = 0; i < 16; i++) begin
      if (i % 4 == 1) idle("R9 idle list1");
      beat(i * 3, 1'b0, 1'b1, bi_ref(i * 15 + 1, i * 3), "R9 bi after gaps");
    end
  endtask

  task automatic t_latch;
    setp(9, 1, 0, 0, 2);
    beat(30, 1'b0, 1'b1, single_ref(30), "R8 first single");
    for (int i = 1; i < 16; i++) beat(i * 9, 1'b1, 1'b1, single_ref(i * 9), "R8 late bipred ignored");
    setp(11, 0, 13, 0, 4);
    beat(100, 1'b1, 1'b0, 0, "R8 first bi");
    for (int i = 1; i < 16; i++) beat(i * 4, 1'b0, 1'b0, 0, "R8 late single ignored");
    for (int i = 0; i < 16; i++) beat(i * 8, 1'b0, 1'b1,
      bi_ref((i == 0) ? 100 : i * 4, i * 8), "R8 bi pass");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_single(); t_log0(); t_wext(); t_clip();
        t_bi(); t_gaps(); t_latch();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule